// File: doc/BRIEF.md
# 8-bit ALU with Carry, Digit Carry and Zero flags

This block is the arithmetic-logic unit of a small accumulator-style core. One operand is always the working register (`w_i`). The other operand (`f_i`) is a file-register value or an immediate literal. The surrounding datapath selects that operand before it reaches the block. A 4-bit operation code picks among these operations:

- addition and subtraction
- AND, OR and XOR
- complement, pass-through and clear
- increment and decrement
- rotate left and rotate right through carry
- nibble swap

The unit registers its outputs once. One cycle after an accepted operation it presents the 8-bit result, the next Carry, Digit Carry and Zero values, and one write strobe per flag. The status register that holds the flags lies outside this block. That register takes a new flag value only when the flag's strobe is high. Each operation raises only the strobes of the flags it affects.

Subtraction computes operand minus working register as `f + ~w + 1`. Carry and Digit Carry therefore read as active-low borrows: 1 means no borrow occurred.

Top module: `alu8_core`

## Requirements
- R1: While `rst_ni` is low, every output is 0, including `valid_o`, `res_o` and all flag values and strobes.
- R2: Every output updates on the rising clock edge at which `valid_i` was sampled. When `valid_i` was low at that edge, `valid_o`, `c_we_o`, `dc_we_o` and `z_we_o` are 0.
- R3: Op 0 (add): `res_o = (w + f) mod 256`, `c_o` = carry out of bit 7, `dc_o` = carry out of bit 3, and all three strobes are 1.
- R4: Op 1 (subtract): `res_o = (f - w) mod 256`, `c_o = 1` iff f >= w, `dc_o = 1` iff f[3:0] >= w[3:0], and all three strobes are 1.
- R5: Ops 2, 3 and 4 give w AND f, w OR f and w XOR f. Only `z_we_o` is 1.
- R6: Op 5 gives the bitwise complement of f, op 11 passes f unchanged and op 12 gives 0. Only `z_we_o` is 1.
- R7: Op 6 gives f + 1 and op 7 gives f - 1, both modulo 256. Only `z_we_o` is 1.
- R8: Op 8 (rotate left) gives `{f[6:0], c_i}` with `c_o = f[7]`. Op 9 (rotate right) gives `{c_i, f[7:1]}` with `c_o = f[0]`. Only `c_we_o` is 1.
- R9: Op 10 swaps the nibbles, giving `{f[3:0], f[7:4]}`, and raises no strobe.
- R10: Ops 13, 14 and 15 are reserved. They give `res_o = f` and raise no strobe.
- R11: Whenever `z_we_o` is 1, `z_o` is 1 exactly when `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File-register or literal operand |
| c_i | input | 1 | Current Carry, used by the rotates |
| valid_o | output | 1 | Result valid |
| res_o | output | 8 | Result |
| c_o | output | 1 | Next Carry value |
| dc_o | output | 1 | Next Digit Carry value |
| z_o | output | 1 | Next Zero value |
| c_we_o | output | 1 | Carry update strobe |
| dc_we_o | output | 1 | Digit Carry update strobe |
| z_we_o | output | 1 | Zero update strobe |

## Verification
On every cycle, the assertions check four properties:

- an idle cycle raises no strobe;
- Zero agrees with the result whenever it is written;
- the add result and carry match the operands of the previous cycle, as do the subtract borrow flag and the rotate-left result;
- a nibble swap raises no strobe.

Only the bench's scenarios cover the rest. They check the full result and flag values of every operation code against an independent model. Addition and subtraction run over all 65,536 operand pairs, and the logical operations over a wide operand sweep. The scenarios also cover the reserved codes and the reset state.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RL   = 4'd8,
    OP_RR   = 4'd9,
    OP_SWAP = 4'd10,
    OP_PASS = 4'd11,
    OP_CLR  = 4'd12,
    OP_RSV0 = 4'd13,
    OP_RSV1 = 4'd14,
    OP_RSV2 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_set_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8,
  parameter int NIB_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             dcout_o
);
  localparam int HI_W = WIDTH - NIB_W;

  logic [NIB_W:0] lo_sum;
  logic [HI_W:0]  hi_sum;

  // split at the digit boundary so the half carry is a real adder output
  always_comb begin
    lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    hi_sum = {1'b0, a_i[WIDTH-1:NIB_W]} + {1'b0, b_i[WIDTH-1:NIB_W]} + {{HI_W{1'b0}}, lo_sum[NIB_W]};
  end

  assign sum_o   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
  assign cout_o  = hi_sum[HI_W];
  assign dcout_o = lo_sum[NIB_W];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             rot_c_o
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  generate
    if (WIDTH % 2 == 0) begin : g_even
      assign swapped = {f_i[HALF-1:0], f_i[WIDTH-1:HALF]};
    end else begin : g_odd
      assign swapped = f_i;
    end
  endgenerate

  always_comb begin
    rot_c_o = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = w_i & f_i;
      OP_OR:   res_o = w_i | f_i;
      OP_XOR:  res_o = w_i ^ f_i;
      OP_COM:  res_o = ~f_i;
      OP_CLR:  res_o = '0;
      OP_SWAP: res_o = swapped;
      OP_RL: begin
        res_o   = {f_i[WIDTH-2:0], c_i};
        rot_c_o = f_i[WIDTH-1];
      end
      OP_RR: begin
        res_o   = {c_i, f_i[WIDTH-1:1]};
        rot_c_o = f_i[0];
      end
      default: res_o = f_i;
    endcase
  end
endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
  import alu8_pkg::*;
(
  input  alu_op_e   op_i,
  output flag_set_t we_o,
  output logic      arith_o,
  output logic      rot_o
);
  always_comb begin
    we_o    = '0;
    arith_o = 1'b0;
    rot_o   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        we_o    = '{c: 1'b1, dc: 1'b1, z: 1'b1};
        arith_o = 1'b1;
      end
      OP_INC, OP_DEC: begin
        we_o.z  = 1'b1;
        arith_o = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_PASS, OP_CLR: we_o.z = 1'b1;
      OP_RL, OP_RR: begin
        we_o.c = 1'b1;
        rot_o  = 1'b1;
      end
      default: we_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic             c_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             dc_o,
  output logic             z_o,
  output logic             c_we_o,
  output logic             dc_we_o,
  output logic             z_we_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] add_a, add_b, add_sum, bit_res, res_d;
  logic             add_cin, add_cout, add_dc, rot_c;
  logic             is_arith, is_rot;
  flag_set_t        we_d, flag_d;

  assign op = alu_op_e'(op_i);

  // one adder serves add, subtract, increment and decrement
  always_comb begin
    add_a   = f_i;
    add_b   = w_i;
    add_cin = 1'b0;
    unique case (op)
      OP_SUB: begin add_b = ~w_i;  add_cin = 1'b1; end
      OP_INC: begin add_b = '0;    add_cin = 1'b1; end
      OP_DEC: begin add_b = '1;    add_cin = 1'b0; end
      default: ;
    endcase
  end

  alu8_addsub #(.WIDTH(WIDTH), .NIB_W(NIB_W)) u_addsub (
    .a_i     (add_a),
    .b_i     (add_b),
    .cin_i   (add_cin),
    .sum_o   (add_sum),
    .cout_o  (add_cout),
    .dcout_o (add_dc)
  );

  alu8_bitops #(.WIDTH(WIDTH)) u_bitops (
    .op_i    (op),
    .w_i     (w_i),
    .f_i     (f_i),
    .c_i     (c_i),
    .res_o   (bit_res),
    .rot_c_o (rot_c)
  );

  alu8_flagsel u_flagsel (
    .op_i    (op),
    .we_o    (we_d),
    .arith_o (is_arith),
    .rot_o   (is_rot)
  );

  always_comb begin
    res_d     = is_arith ? add_sum : bit_res;
    flag_d.c  = is_rot ? rot_c : add_cout;
    flag_d.dc = add_dc;
    flag_d.z  = (res_d == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      c_o     <= 1'b0;
      dc_o    <= 1'b0;
      z_o     <= 1'b0;
      c_we_o  <= 1'b0;
      dc_we_o <= 1'b0;
      z_we_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      c_we_o  <= valid_i & we_d.c;
      dc_we_o <= valid_i & we_d.dc;
      z_we_o  <= valid_i & we_d.z;
      if (valid_i) begin
        res_o <= res_d;
        c_o   <= flag_d.c;
        dc_o  <= flag_d.dc;
        z_o   <= flag_d.z;
      end
    end
  end
endmodule

// File: rtl/alu8_core_sva.sv
module alu8_core_sva
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] w_i,
  input logic [WIDTH-1:0] f_i,
  input logic             c_i,
  input logic             valid_o,
  input logic [WIDTH-1:0] res_o,
  input logic             c_o,
  input logic             z_o,
  input logic             c_we_o,
  input logic             dc_we_o,
  input logic             z_we_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(c_we_o || dc_we_o || z_we_o)); // R2

  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && z_we_o) |-> (z_o == (res_o == '0))); // R11

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(op_i) == OP_ADD) |->
      ({c_o, res_o} == ({1'b0, $past(w_i)} + {1'b0, $past(f_i)}))); // R3

  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(op_i) == OP_SUB) |->
      (c_o == ($past(f_i) >= $past(w_i)))); // R4

  AST_ROT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(op_i) == OP_RL) |->
      (res_o == {$past(f_i[WIDTH-2:0]), $past(c_i)} && c_we_o && !z_we_o)); // R8

  AST_SWAP_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && $past(op_i) == OP_SWAP) |->
      !(c_we_o || dc_we_o || z_we_o)); // R9
endmodule

bind alu8_core alu8_core_sva #(.WIDTH(WIDTH)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .w_i     (w_i),
  .f_i     (f_i),
  .c_i     (c_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .c_o     (c_o),
  .z_o     (z_o),
  .c_we_o  (c_we_o),
  .dc_we_o (dc_we_o),
  .z_we_o  (z_we_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] w_i = '0, f_i = '0;
  logic       c_i = 1'b0;
  logic       valid_o, c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o;
  logic [7:0] res_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alu8_core u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .w_i, .f_i, .c_i,
    .valid_o, .res_o, .c_o, .dc_o, .z_o, .c_we_o, .dc_we_o, .z_we_o
  );

  // expected: {res, c, dc, z, we_c, we_dc, we_z}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] w,
                                        input logic [7:0] f, input logic cin);
    logic [7:0] r;
    logic c, dc;
    logic [2:0] we;
    c = 1'b0; dc = 1'b0; we = 3'b000; r = f;
    case (op)
      4'd0: begin r = w + f; c = (int'(w) + int'(f)) > 255;
                  dc = (int'(w[3:0]) + int'(f[3:0])) > 15; we = 3'b111; end
      4'd1: begin r = f - w; c = f >= w; dc = f[3:0] >= w[3:0]; we = 3'b111; end
      4'd2: begin r = w & f; we = 3'b001; end
      4'd3: begin r = w | f; we = 3'b001; end
      4'd4: begin r = w ^ f; we = 3'b001; end
      4'd5: begin r = ~f; we = 3'b001; end
      4'd6: begin r = f + 8'd1; we = 3'b001; end
      4'd7: begin r = f - 8'd1; we = 3'b001; end
      4'd8: begin r = {f[6:0], cin}; c = f[7]; we = 3'b100; end
      4'd9: begin r = {cin, f[7:1]}; c = f[0]; we = 3'b100; end
      4'd10: begin r = {f[3:0], f[7:4]}; we = 3'b000; end
      4'd11: begin r = f; we = 3'b001; end
      4'd12: begin r = 8'd0; we = 3'b001; end
      default: begin r = f; we = 3'b000; end
    endcase
    return {r, c, dc, (r == 8'd0), we};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                       input logic cin, input string req);
    logic [13:0] e;
    logic bad;
    e = model(op, w, f, cin);
    op_i = op; w_i = w; f_i = f; c_i = cin; valid_i = 1'b1;
    @(negedge clk_i);
    n_vec++;
    bad = !valid_o || res_o != e[13:6] || {c_we_o, dc_we_o, z_we_o} != e[2:0] ||
          (e[2] && c_o != e[5]) || (e[1] && dc_o != e[4]) || (e[0] && z_o != e[3]);
    if (bad) begin
      n_bad++;
      $display("FAIL %s op=%0d w=%02h f=%02h c=%0b: got v=%0b res=%02h cdz=%0b%0b%0b we=%03b exp res=%02h cdz=%03b we=%03b",
               req, op, w, f, cin, valid_o, res_o, c_o, dc_o, z_o,
               {c_we_o, dc_we_o, z_we_o}, e[13:6], e[5:3], e[2:0]);
    end
  endtask

  task automatic t_reset();
    n_vec++;
    if ({valid_o, res_o, c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o} != '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs got v=%0b res=%02h exp all zero", valid_o, res_o);
    end
  endtask

  task automatic t_add();
    for (int w = 0; w < 256; w++)
      for (int f = 0; f < 256; f++) apply(4'd0, 8'(w), 8'(f), 1'b0, "R3");
  endtask

  task automatic t_sub();
    for (int w = 0; w < 256; w++)
      for (int f = 0; f < 256; f++) apply(4'd1, 8'(w), 8'(f), 1'b1, "R4");
  endtask

  task automatic t_logic();
    for (int op = 2; op <= 4; op++)
      for (int w = 0; w < 256; w += 17)
        for (int f = 0; f < 256; f++) apply(4'(op), 8'(w), 8'(f), 1'b0, "R5");
  endtask

  task automatic t_unary();
    for (int f = 0; f < 256; f++) begin
      apply(4'd5, 8'h5a, 8'(f), 1'b1, "R6");
      apply(4'd11, 8'ha5, 8'(f), 1'b0, "R6");
      apply(4'd12, 8'(f), 8'(f), 1'b1, "R6");
      apply(4'd6, 8'h00, 8'(f), 1'b0, "R7");
      apply(4'd7, 8'hff, 8'(f), 1'b1, "R7");
    end
  endtask

  task automatic t_rotate();
    for (int f = 0; f < 256; f++)
      for (int c = 0; c < 2; c++) begin
        apply(4'd8, 8'h00, 8'(f), 1'(c), "R8");
        apply(4'd9, 8'h00, 8'(f), 1'(c), "R8");
      end
  endtask

  task automatic t_swap_reserved();
    for (int f = 0; f < 256; f++) begin
      apply(4'd10, 8'h33, 8'(f), 1'b1, "R9");
      apply(4'd13, 8'h00, 8'(f), 1'b1, "R10");
      apply(4'd14, 8'hff, 8'(f), 1'b0, "R10");
      apply(4'd15, 8'h81, 8'(f), 1'b1, "R10");
    end
  endtask

  task automatic t_idle();
    // a full-strobe op offered while idle must raise nothing
    op_i = 4'd0; w_i = 8'h10; f_i = 8'h20; valid_i = 1'b0;
    @(negedge clk_i);
    n_vec++;
    if (valid_o || c_we_o || dc_we_o || z_we_o) begin
      n_bad++;
      $display("FAIL R2 idle got v=%0b we=%03b exp v=0 we=000",
               valid_o, {c_we_o, dc_we_o, z_we_o});
    end
    // zero-result corner cases for R11 and the latency rule R2
    apply(4'd0, 8'h80, 8'h80, 1'b0, "R11");
    apply(4'd1, 8'h42, 8'h42, 1'b0, "R11");
    apply(4'd6, 8'h00, 8'hff, 1'b0, "R11");
    apply(4'd2, 8'hf0, 8'h0f, 1'b0, "R2");
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_rotate();
    t_swap_reserved();
    t_idle();
    valid_i = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule